// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block decides, once per cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline must wait one cycle for a load that is now in the execute stage. It examines two latched instruction words: the one in the decode/execute latch (the possible load) and the one in the fetch/decode latch (the possible consumer). When the consumer reads the load's destination register before any forwarding path can supply it, the block raises a stall. The stall freezes the program counter and the fetch/decode latch, and it replaces the decode/execute latch contents with a no-op bubble.

Which source fields are compared depends on the kind of instruction being decoded. A register-register operation reads two registers, so both of its source fields are compared. A load, a store, an immediate ALU operation or a conditional branch is compared on its first source field only, because that field is the only register it reads early. A load that writes register 0 never stalls. After the single bubble cycle, the load result reaches the consumer through the load-data forwarding path from the memory/writeback latch. A one-bit guard stops the stall from lasting more than one cycle.

Top module: `load_use_interlock`

## Requirements
- R1: A stall is considered only when the opcode of `ex_instr` is 6'h23 (load). Fields are opcode [31:26], first source rs [25:21] and second field rt [20:16]. The load's destination is its rt field. Any other opcode in `ex_instr` (for example store 6'h2B or immediate add 6'h08) never stalls.
- R2: When `id_instr` has opcode 6'h00 (register-register), a stall is raised if the load's rt equals the rs of `id_instr`.
- R3: When `id_instr` has opcode 6'h00, a stall is also raised if the load's rt equals the rt of `id_instr`.
- R4: When `id_instr` is a load (6'h23), a store (6'h2B), an immediate ALU op (6'h08 to 6'h0E) or a branch (6'h04, 6'h05), only its rs is compared. A match on its rt alone does not stall.
- R5: Any other opcode in `id_instr` (for example jump 6'h02) never stalls, whatever its register fields hold.
- R6: A load whose rt is 0 never stalls.
- R7: While `stall` is 1, `pc_we` and `ifid_we` are 0 and `bubble` is 1. While `stall` is 0, `pc_we` and `ifid_we` are 1 and `bubble` is 0.
- R8: A stall lasts exactly one cycle. If the same hazard is still presented in the cycle after a stall, `stall` is 0 in that cycle. It can rise again one cycle later.
- R9: While `rst_n` is low, the one-cycle guard is held clear. A hazard presented during reset, or in the first cycle after reset, therefore raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_instr | input | 32 | Instruction word held in the decode/execute latch |
| id_instr | input | 32 | Instruction word held in the fetch/decode latch |
| stall | output | 1 | Hazard detected; issue is stopped this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode latch write enable |
| bubble | output | 1 | Load a no-op into the decode/execute latch |

## Verification
The hardest situation to reach from the ports is the one-cycle limit. In a real pipeline the bubble removes the load from the execute latch, so a hazard held for two cycles in a row never arises. The bench reaches it by holding a matching load/consumer pair on the inputs for three consecutive cycles and expecting stall to read 1, 0, 1. Reset is exercised with a hazard already on the inputs, so a guard that wakes up set is exposed. A class-by-field table checks that a match in a field the consumer's class does not read (rt of a store, an immediate op or a jump) leaves the outputs at their free-running values.

// File: rtl/lui_pkg.sv
// Package: shared instruction class type for the load-use interlock.
// Assumes a fixed-format encoding with opcode, rs and rt at the top of the word.
package lui_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER  = 3'd0,
        CLS_RR     = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_ALUI   = 3'd4,
        CLS_BRANCH = 3'd5
    } instr_class_e;

endpackage

// File: rtl/lui_decode.sv
// Module: lui_decode
// Classifies one instruction word and extracts its rs and rt fields.
// Assumes opcode occupies the top OPC_W bits, followed by rs then rt.
module lui_decode
    import lui_pkg::*;
#(
    parameter int unsigned     INSTR_W     = 32,
    parameter int unsigned     OPC_W       = 6,
    parameter int unsigned     REG_W       = 5,
    parameter logic [OPC_W-1:0] OP_RR      = 6'h00,
    parameter logic [OPC_W-1:0] OP_LOAD    = 6'h23,
    parameter logic [OPC_W-1:0] OP_STORE   = 6'h2B,
    parameter logic [OPC_W-1:0] OP_ALUI_LO = 6'h08,
    parameter logic [OPC_W-1:0] OP_ALUI_HI = 6'h0E,
    parameter logic [OPC_W-1:0] OP_BR_A    = 6'h04,
    parameter logic [OPC_W-1:0] OP_BR_B    = 6'h05
) (
    input  logic [INSTR_W-1:0] instr,
    output instr_class_e       cls,
    output logic [REG_W-1:0]   rs,
    output logic [REG_W-1:0]   rt
);
    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
    localparam int unsigned RT_LSB  = RS_LSB - REG_W;

    logic [OPC_W-1:0] opc;
    logic             unused_low;

    // Field extraction.
    assign opc        = instr[INSTR_W-1:OPC_LSB];
    assign rs         = instr[OPC_LSB-1:RS_LSB];
    assign rt         = instr[RS_LSB-1:RT_LSB];
    assign unused_low = ^instr[RT_LSB-1:0];

    // Opcode to class mapping.
    always_comb begin
        if (opc == OP_RR)                                 cls = CLS_RR;
        else if (opc == OP_LOAD)                          cls = CLS_LOAD;
        else if (opc == OP_STORE)                         cls = CLS_STORE;
        else if (opc >= OP_ALUI_LO && opc <= OP_ALUI_HI)  cls = CLS_ALUI;
        else if (opc == OP_BR_A || opc == OP_BR_B)        cls = CLS_BRANCH;
        else                                              cls = CLS_OTHER;
    end
endmodule

// File: rtl/lui_match.sv
// Module: lui_match
// Compares the load destination against the source fields the decoding
// instruction actually reads. Assumes register 0 is hard-wired zero.
module lui_match
    import lui_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  instr_class_e     ex_cls,
    input  logic [REG_W-1:0] ex_rt,
    input  instr_class_e     id_cls,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    output logic             hit
);
    logic load_live;
    logic rs_read;
    logic rt_read;

    // Producer qualifies: a load writing a real register.
    assign load_live = (ex_cls == CLS_LOAD) && (ex_rt != '0);

    // Which consumer fields are read in decode, by class.
    always_comb begin
        rs_read = 1'b0;
        rt_read = 1'b0;
        case (id_cls)
            CLS_RR:                                 begin rs_read = 1'b1; rt_read = 1'b1; end
            CLS_LOAD, CLS_STORE, CLS_ALUI, CLS_BRANCH: rs_read = 1'b1;
            default:                                ;
        endcase
    end

    // Hazard when a read field names the load destination.
    assign hit = load_live &&
                 ((rs_read && (id_rs == ex_rt)) || (rt_read && (id_rt == ex_rt)));
endmodule

// File: rtl/lui_ctrl.sv
// Module: lui_ctrl
// Turns a raw hazard into one stall cycle and drives the pipeline controls.
// Assumes the bubble removes the load from the execute latch next cycle.
module lui_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic stall,
    output logic pc_we,
    output logic ifid_we,
    output logic bubble
);
    logic guard_q;

    // Remember that the previous cycle stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) guard_q <= 1'b0;
        else        guard_q <= stall;
    end

    // One-cycle stall and the derived enables.
    assign stall   = hit && !guard_q;
    assign pc_we   = !stall;
    assign ifid_we = !stall;
    assign bubble  = stall;
endmodule

// File: rtl/load_use_interlock.sv
// Module: load_use_interlock (top)
// Detects a load-use hazard between the execute-stage load and the decoding
// instruction, and holds fetch for one cycle while a bubble issues.
// Assumes a five-stage in-order pipeline with load-data forwarding from MEM/WB.
module load_use_interlock
    import lui_pkg::*;
#(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned OPC_W   = 6,
    parameter int unsigned REG_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] ex_instr,
    input  logic [INSTR_W-1:0] id_instr,
    output logic               stall,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               bubble
);
    localparam int unsigned N_STAGE = 2;

    logic [INSTR_W-1:0] words [N_STAGE];
    instr_class_e       cls   [N_STAGE];
    logic [REG_W-1:0]   rs    [N_STAGE];
    logic [REG_W-1:0]   rt    [N_STAGE];
    logic               hit;
    logic               unused_ex_rs;

    // Stage 0 is execute, stage 1 is decode.
    assign words[0]     = ex_instr;
    assign words[1]     = id_instr;
    assign unused_ex_rs = ^rs[0];

    // One decoder per latched instruction.
    for (genvar g = 0; g < N_STAGE; g++) begin : g_dec
        lui_decode #(
            .INSTR_W (INSTR_W),
            .OPC_W   (OPC_W),
            .REG_W   (REG_W)
        ) u_dec (
            .instr (words[g]),
            .cls   (cls[g]),
            .rs    (rs[g]),
            .rt    (rt[g])
        );
    end

    lui_match #(.REG_W(REG_W)) u_match (
        .ex_cls (cls[0]),
        .ex_rt  (rt[0]),
        .id_cls (cls[1]),
        .id_rs  (rs[1]),
        .id_rt  (rt[1]),
        .hit    (hit)
    );

    lui_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .stall   (stall),
        .pc_we   (pc_we),
        .ifid_we (ifid_we),
        .bubble  (bubble)
    );
endmodule

// File: rtl/lui_checker.sv
// Module: lui_checker
// Port-level properties of the load-use interlock, bound to the top.
module lui_checker #(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned OPC_W   = 6,
    parameter int unsigned REG_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] ex_instr,
    input logic [INSTR_W-1:0] id_instr,
    input logic               stall,
    input logic               pc_we,
    input logic               ifid_we,
    input logic               bubble
);
    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
    localparam int unsigned RT_LSB  = RS_LSB - REG_W;

    logic [OPC_W-1:0] ex_op, id_op;
    logic [REG_W-1:0] ex_rt, id_rs;
    logic             unused_chk;

    assign ex_op      = ex_instr[INSTR_W-1:OPC_LSB];
    assign id_op      = id_instr[INSTR_W-1:OPC_LSB];
    assign ex_rt      = ex_instr[RS_LSB-1:RT_LSB];
    assign id_rs      = id_instr[OPC_LSB-1:RS_LSB];
    assign unused_chk = ^{ex_instr[OPC_LSB-1:RS_LSB], ex_instr[RT_LSB-1:0], id_instr[RS_LSB-1:0]};

    AST_ONLY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_op != 6'h23) |-> !stall);                                          // R1
    AST_RR_RS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_op == 6'h23 && ex_rt != '0 && id_op == 6'h00 && id_rs == ex_rt && !$past(stall))
        |-> stall);                                                            // R2
    AST_JUMP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_op == 6'h02) |-> !stall);                                          // R5
    AST_ZERO_DEST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rt == '0) |-> !stall);                                             // R6
    AST_HOLD_CONTROLS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!pc_we && !ifid_we && bubble));                             // R7
    AST_FREE_CONTROLS: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (pc_we && ifid_we && !bubble));                             // R7
    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);                                                     // R8
endmodule

bind load_use_interlock lui_checker #(
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .REG_W   (REG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_instr (ex_instr),
    .id_instr (id_instr),
    .stall    (stall),
    .pc_we    (pc_we),
    .ifid_we  (ifid_we),
    .bubble   (bubble)
);

// File: tb/sim_load_use_interlock.sv
module sim_load_use_interlock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ex_instr = '0;
    logic [31:0] id_instr = '0;
    logic        stall, pc_we, ifid_we, bubble;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    load_use_interlock u0 (
        .clk(clk), .rst_n(rst_n), .ex_instr(ex_instr), .id_instr(id_instr),
        .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
    );

    typedef struct packed {
        logic [31:0] ex;
        logic [31:0] id;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h00,5'd5,5'd7,16'h0820}, 1'b1, 4'd2},  // R2 rs match
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h00,5'd3,5'd5,16'h0820}, 1'b1, 4'd3},  // R3 rt match
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h00,5'd3,5'd4,16'h0820}, 1'b0, 4'd2},  // R2 no match
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h2B,5'd5,5'd9,16'h0004}, 1'b1, 4'd4},  // R4 store base
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h2B,5'd2,5'd5,16'h0004}, 1'b0, 4'd4},  // R4 store data ignored
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h08,5'd9,5'd5,16'h0001}, 1'b0, 4'd4},  // R4 imm dest ignored
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h04,5'd5,5'd1,16'h0010}, 1'b1, 4'd4},  // R4 branch
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h23,5'd5,5'd6,16'h0000}, 1'b1, 4'd4},  // R4 load base
        '{{6'h23,5'd2,5'd5,16'h0}, {6'h02,5'd5,5'd5,16'h0000}, 1'b0, 4'd5},  // R5 jump
        '{{6'h2B,5'd2,5'd5,16'h0}, {6'h00,5'd5,5'd5,16'h0820}, 1'b0, 4'd1},  // R1 store in EX
        '{{6'h08,5'd2,5'd5,16'h0}, {6'h00,5'd5,5'd5,16'h0820}, 1'b0, 4'd1},  // R1 imm in EX
        '{{6'h23,5'd2,5'd0,16'h0}, {6'h00,5'd0,5'd0,16'h0020}, 1'b0, 4'd6},  // R6 zero dest
        '{{6'h23,5'd2,5'd31,16'h0},{6'h0D,5'd31,5'd3,16'h00FF},1'b1, 4'd4}   // R4 ori rs=31
    };

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // R7 control pattern follows the stall.
    task automatic check_ctrl(input logic exp_stall);
        check(stall, exp_stall, "R7", "stall");
        check(pc_we & ifid_we & ~bubble, ~exp_stall, "R7", "controls");
    endtask

    task automatic drive(input logic [31:0] ex, input logic [31:0] id);
        @(posedge clk); #1;
        ex_instr = ex;
        id_instr = id;
        #2;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9: hazard present during reset still stalls, guard held clear.
        drive({6'h23,5'd2,5'd5,16'h0}, {6'h00,5'd5,5'd7,16'h0});
        check(stall, 1'b1, "R9", "stall in reset c1");
        drive({6'h23,5'd2,5'd5,16'h0}, {6'h00,5'd5,5'd7,16'h0});
        check(stall, 1'b1, "R9", "stall in reset c2");
        @(posedge clk); #1; rst_n = 1'b1; #2;
        check(stall, 1'b1, "R9", "stall first cycle after reset");
        drive('0, '0);
        check_ctrl(1'b0);

        // Table of class/field vectors, each after a nop cycle.
        for (int i = 0; i < NV; i++) begin
            drive('0, '0);
            drive(VECS[i].ex, VECS[i].id);
            n_chk++;
            if (stall !== VECS[i].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: got %0b expected %0b", VECS[i].req, i, stall, VECS[i].exp);
            end
            check(pc_we & ifid_we & ~bubble, ~VECS[i].exp, "R7", "vector controls");
        end

        // R8: held hazard alternates 1,0,1.
        drive('0, '0);
        drive({6'h23,5'd1,5'd9,16'h0}, {6'h00,5'd4,5'd9,16'h0});
        check(stall, 1'b1, "R8", "held hazard c1");
        drive({6'h23,5'd1,5'd9,16'h0}, {6'h00,5'd4,5'd9,16'h0});
        check(stall, 1'b0, "R8", "held hazard c2");
        check(pc_we, 1'b1, "R8", "pc_we released");
        drive({6'h23,5'd1,5'd9,16'h0}, {6'h00,5'd4,5'd9,16'h0});
        check(stall, 1'b1, "R8", "held hazard c3");

        // R6 with the zero register on both consumer fields and a branch.
        drive('0, '0);
        drive({6'h23,5'd7,5'd0,16'h0}, {6'h05,5'd0,5'd0,16'h0});
        check(stall, 1'b0, "R6", "zero dest branch");
        // R5 with an unlisted opcode (6'h0F) reading matching fields.
        drive({6'h23,5'd7,5'd3,16'h0}, {6'h0F,5'd3,5'd3,16'h0});
        check(stall, 1'b0, "R5", "opcode 0F");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule